// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is one 16-bit pulse-width-modulation channel. A counter runs upward from zero while the channel runs. When it reaches the period register, it returns to zero on the next clock, so one period lasts the period value plus one clocks. The output pin goes high at the start of each period and goes low on the clock after the counter reaches the active width register.

Software does not change the active width directly while the channel runs. It writes a staging register instead, as often as it likes. Only the value present in that register when the counter reaches the period value is loaded into the active width. The new width therefore starts exactly at the next period boundary, and the waveform never shows a torn pulse. The same period match sets a sticky flag. Software clears the flag by writing one to a clear bit. An interrupt request is the flag gated by an enable bit.

A small controller has two states, `ST_STOP` and `ST_RUN`. The transition `ST_STOP -> ST_RUN` is taken on the first clock at which the run bit is seen set. If the counter is zero at that clock, a new period begins. The transition `ST_RUN -> ST_STOP` is taken on the first clock at which the run bit is seen clear. In `ST_STOP` the counter and the output hold their values.

Top module: `bpwm_channel`

## Requirements
- R1: Reset clears the output pin, the match flag, the interrupt request, the counter and all registers to zero.
- R2: While running, the counter steps by one per clock. On the clock after it equals the period value it becomes zero, so a period lasts period+1 clocks.
- R3: On the period-match clock, the staging value is copied into the active width. Staging writes made earlier in the period leave only the last value. Width writes made while running are ignored.
- R4: With a live width W (W not 0 and not equal to the period value), the output is high for W+1 clocks from the count of zero and low for the rest of the period. If W is greater than the period value, the output stays high for the whole period.
- R5: If the width governing a period is 0 or equals the period value, the output keeps the level it had when that period began.
- R6: The match flag sets on every period match and stays set until a control write has bit 2 at one. A match in the same clock as a clear leaves the flag set.
- R7: The interrupt request is high exactly when the match flag and the interrupt-enable bit (control bit 1) are both one.
- R8: With control bit 0 at zero the channel stops: the counter and the output hold their values. Setting the bit again resumes from the held count without starting a new period.
- R9: Width writes while stopped take effect at once, so the first period after start uses them.
- R10: Register select codes: 0 period, 1 active width, 2 staging, 3 control (bit 0 run, bit 1 interrupt enable, bit 2 flag clear, which is not stored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM output pin |
| match_flag_o | output | 1 | Sticky period-match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes take effect at the clock that captures them. A flag clear shows on the flag at that same clock, and the interrupt request follows the enable bit at that clock because it is combinational. After a run bit is captured, the controller needs one more clock to enter `ST_RUN`, and the output rises at that clock. Each later output change appears one clock after the counter reaches the width or the period value. The bench drives on falling edges and samples on the next falling edge, and it counts high samples per period of period+1 samples instead of timing single edges. The freeze case counts the held samples and the high samples after resume separately.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    typedef enum logic [1:0] {
        REG_CYCLE = 2'd0,
        REG_DUTY  = 2'd1,
        REG_STAGE = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_IEN_BIT = 1;
    localparam int CTRL_CLR_BIT = 2;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs
    import bpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         running,
    input  logic         match,
    output logic [W-1:0] cycle_q,
    output logic [W-1:0] duty_q,
    output logic [W-1:0] stage_q,
    output logic         run_en_q,
    output logic         irq_en_q,
    output logic         clr_pulse
);

    logic wr_cycle, wr_duty, wr_stage, wr_ctrl;

    always_comb begin
        wr_cycle  = wr_en && (reg_sel_e'(wr_sel) == REG_CYCLE);
        wr_duty   = wr_en && (reg_sel_e'(wr_sel) == REG_DUTY);
        wr_stage  = wr_en && (reg_sel_e'(wr_sel) == REG_STAGE);
        wr_ctrl   = wr_en && (reg_sel_e'(wr_sel) == REG_CTRL);
        clr_pulse = wr_ctrl && wr_data[CTRL_CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cycle_q  <= '0;
            stage_q  <= '0;
            run_en_q <= 1'b0;
            irq_en_q <= 1'b0;
        end else begin
            if (wr_cycle) cycle_q <= wr_data;
            if (wr_stage) stage_q <= wr_data;
            if (wr_ctrl) begin
                run_en_q <= wr_data[CTRL_RUN_BIT];
                irq_en_q <= wr_data[CTRL_IEN_BIT];
            end
        end
    end

    // Active width: reload from staging at the boundary, direct write only when stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            duty_q <= '0;
        else if (match)
            duty_q <= stage_q;
        else if (wr_duty && !running)
            duty_q <= wr_data;
    end

    // R3: boundary reload takes the staging value
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> duty_q == $past(stage_q));

    // R3: the active width is locked during a running period
    a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
        running && !match |=> $stable(duty_q));

endmodule

// File: rtl/bpwm_counter.sv
module bpwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic [W-1:0] cycle_q,
    input  logic [W-1:0] duty_q,
    output logic [W-1:0] cnt_q,
    output logic         at_cycle,
    output logic         at_duty
);

    always_comb begin
        at_cycle = (cnt_q == cycle_q);
        at_duty  = (cnt_q == duty_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (count_en) begin
            if (at_cycle) cnt_q <= '0;
            else          cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && at_cycle |=> cnt_q == '0);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && !at_cycle |=> cnt_q == W'($past(cnt_q) + 1'b1));

    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(cnt_q));

endmodule

// File: rtl/bpwm_wave.sv
module bpwm_wave
    import bpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] cnt_q,
    input  logic         at_cycle,
    input  logic         at_duty,
    input  logic [W-1:0] cycle_q,
    input  logic [W-1:0] duty_q,
    input  logic [W-1:0] stage_q,
    output logic         running,
    output logic         count_en,
    output logic         match,
    output logic         pwm_o
);

    run_state_e state_q, state_d;
    logic start_period, duty_live, stage_live, pwm_d;

    function automatic logic width_live(input logic [W-1:0] wv, input logic [W-1:0] cv);
        return (wv != '0) && (wv != cv);
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_STOP;
        endcase
    end

    always_comb begin
        running      = (state_q == ST_RUN);
        count_en     = running && run_en;
        match        = count_en && at_cycle;
        start_period = (state_q == ST_STOP) && run_en && (cnt_q == '0);
        duty_live    = width_live(duty_q, cycle_q);
        stage_live   = width_live(stage_q, cycle_q);
        pwm_d        = pwm_o;
        if (match) begin
            if (stage_live) pwm_d = 1'b1;
        end else if (start_period) begin
            if (duty_live) pwm_d = 1'b1;
        end else if (count_en && at_duty && duty_live) begin
            pwm_d = 1'b0;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_o <= 1'b0;
        else        pwm_o <= pwm_d;
    end

    a_r4_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> cnt_q == '0);

    a_r4_fall_at_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_o) |-> $past(cnt_q) == $past(duty_q));

    a_r5_silent_period: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && !at_cycle && (duty_q == '0 || duty_q == cycle_q) |=> $stable(pwm_o));

    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) && !run_en |=> $stable(pwm_o));

endmodule

// File: rtl/bpwm_flag.sv
module bpwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr_pulse,
    input  logic irq_en,
    output logic flag_q,
    output logic irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (match)     flag_q <= 1'b1;
        else if (clr_pulse) flag_q <= 1'b0;
    end

    always_comb irq_o = flag_q && irq_en;

    a_r6_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !clr_pulse |=> flag_q);

    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(match));

endmodule

// File: rtl/bpwm_channel.sv
module bpwm_channel
    import bpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pwm_o,
    output logic         match_flag_o,
    output logic         irq_o
);

    logic [W-1:0] cycle_q, duty_q, stage_q, cnt_q;
    logic run_en_q, irq_en_q, clr_pulse;
    logic running, count_en, match, at_cycle, at_duty;

    bpwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .running  (running),
        .match    (match),
        .cycle_q  (cycle_q),
        .duty_q   (duty_q),
        .stage_q  (stage_q),
        .run_en_q (run_en_q),
        .irq_en_q (irq_en_q),
        .clr_pulse(clr_pulse)
    );

    bpwm_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(count_en),
        .cycle_q (cycle_q),
        .duty_q  (duty_q),
        .cnt_q   (cnt_q),
        .at_cycle(at_cycle),
        .at_duty (at_duty)
    );

    bpwm_wave #(.W(W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en_q),
        .cnt_q   (cnt_q),
        .at_cycle(at_cycle),
        .at_duty (at_duty),
        .cycle_q (cycle_q),
        .duty_q  (duty_q),
        .stage_q (stage_q),
        .running (running),
        .count_en(count_en),
        .match   (match),
        .pwm_o   (pwm_o)
    );

    bpwm_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .clr_pulse(clr_pulse),
        .irq_en   (irq_en_q),
        .flag_q   (match_flag_o),
        .irq_o    (irq_o)
    );

    // R7: a request needs both the flag and the enable
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> match_flag_o && irq_en_q);

endmodule

// File: tb/tb_bpwm_channel.sv
module tb_bpwm_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm, flag, irq;

    int total = 0;
    int bad = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bpwm_channel #(.W(16)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .pwm_o       (pwm),
        .match_flag_o(flag),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [15:0] cyc;
        logic [15:0] duty;
        logic [15:0] stage;
        logic        ien;
        logic [15:0] hi1;
        logic [15:0] hi2;
    } vec_t;

    // period, first width, staged width, irq enable, expected high samples per period
    localparam int NV = 5;
    localparam vec_t VECS [0:NV-1] = '{
        '{16'd9, 16'd3, 16'd6, 1'b1, 16'd4, 16'd7},
        '{16'd5, 16'd0, 16'd2, 1'b0, 16'd0, 16'd3},
        '{16'd7, 16'd7, 16'd4, 1'b1, 16'd0, 16'd5},
        '{16'd6, 16'd2, 16'd6, 1'b0, 16'd3, 16'd0},
        '{16'd5, 16'd8, 16'd5, 1'b1, 16'd6, 16'd6}
    };

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 100000 && !done) begin
            done = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: all requirements, cycles=%0d expected<=100000", cyc_cnt);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // starts and ends at a falling edge; the write lands at the rising edge between
    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        int hi_a, hi_b, hold_hi, resume_hi;
        bit seen_low;

        // R1: reset state
        do_reset();
        check("R1 pwm after reset", pwm, 0);
        check("R1 flag after reset", flag, 0);
        check("R1 irq after reset", irq, 0);

        // Table walk: R2 R4 R5 R9 R10, plus R6 and R7 after two matches
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(2'd0, VECS[v].cyc);
            wr(2'd1, VECS[v].duty);
            wr(2'd2, VECS[v].stage);
            wr(2'd3, {14'd0, VECS[v].ien, 1'b1});
            hi_a = 0;
            hi_b = 0;
            for (int n = 1; n <= 2 * (int'(VECS[v].cyc) + 1); n++) begin
                @(negedge clk);
                if (n <= int'(VECS[v].cyc) + 1) hi_a += int'(pwm);
                else                            hi_b += int'(pwm);
            end
            check($sformatf("R2 R4 R5 R9 vec%0d first period high", v), hi_a, int'(VECS[v].hi1));
            check($sformatf("R2 R3 R4 R5 vec%0d second period high", v), hi_b, int'(VECS[v].hi2));
            check($sformatf("R6 vec%0d flag after matches", v), flag, 1);
            check($sformatf("R7 vec%0d irq", v), irq, int'(VECS[v].ien));
        end

        // R1: reset in the middle of a high pulse
        check("R1 pwm high before reset", pwm, 1);
        do_reset();
        check("R1 pwm cleared by reset", pwm, 0);
        check("R1 flag cleared by reset", flag, 0);

        // R3: staging rewritten mid-period, width write ignored while running
        do_reset();
        wr(2'd0, 16'd9);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd1);
        wr(2'd3, 16'd1);
        hi_a = 0;
        hi_b = 0;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            if (n <= 10) hi_a += int'(pwm);
            else         hi_b += int'(pwm);
            wr_en = 1'b0;
            if (n == 2) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'd5; end
            if (n == 3) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'd2; end
            if (n == 4) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd8; end
        end
        wr_en = 1'b0;
        check("R3 first period keeps initial width", hi_a, 4);
        check("R3 second period uses last staged value", hi_b, 3);

        // R8: stop mid-pulse, hold, resume from held count
        do_reset();
        wr(2'd0, 16'd9);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd5);
        wr(2'd3, 16'd1);
        for (int n = 1; n <= 3; n++) @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'd0;
        @(negedge clk);
        wr_en = 1'b0;
        hold_hi = 0;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            hold_hi += int'(pwm);
        end
        check("R8 output held while stopped", hold_hi, 6);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'd1;
        resume_hi = 0;
        seen_low = 1'b0;
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!pwm) seen_low = 1'b1;
            if (!seen_low) resume_hi++;
        end
        check("R8 high samples after resume", resume_hi, 4);

        // R6 R7: flag set, clear race, clear, interrupt gating
        do_reset();
        wr(2'd0, 16'd0);
        wr(2'd3, 16'b011);
        repeat (3) @(negedge clk);
        check("R6 flag sets on match", flag, 1);
        check("R7 irq with enable", irq, 1);
        wr(2'd3, 16'b111);
        check("R6 match wins over clear", flag, 1);
        wr(2'd3, 16'b010);
        repeat (4) @(negedge clk);
        check("R6 flag sticky while stopped", flag, 1);
        wr(2'd3, 16'b110);
        check("R6 write-one clear", flag, 0);
        check("R7 irq drops with flag", irq, 0);
        wr(2'd3, 16'b001);
        repeat (3) @(negedge clk);
        check("R7 irq masked with flag set", irq, 0);
        wr(2'd3, 16'b011);
        check("R7 irq follows enable", irq, 1);
        wr(2'd3, 16'b001);
        check("R7 irq off again", irq, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule